// File: doc/BRIEF.md
# Byte-Wide Configuration Load Port

This block is the device-side end of a parallel configuration link. A host drives an 8-bit bus on an external configuration clock, selects the port with an active-low select and picks the transfer direction with an active-low write/read line. Bytes written by the host go into a small store that a slower downstream consumer empties at a fixed pace. While the store is full, a busy flag tells the host to keep the current byte on the bus until it is taken.

With the direction line set to read, the port returns the bytes it was loaded with, in the order they arrived. A readback memory that keeps a copy of every accepted byte supplies them. Once a set number of bytes has reached the consumer, configuration counts as complete and a done flag rises. A strap input then decides what the port does next. With the strap set, the port keeps working. With the strap clear, it stops driving every output and ignores the host, so that user logic can take the pins over.

Top module: `cfg_byte_port`

## Requirements
- R1: A byte on `din` is accepted at a rising `clk` edge only when `cs_n` is 0, `rdwr_n` is 0, `busy` is 0 and the port is active. Accepted bytes appear on `cons_data` in acceptance order, each exactly once.
- R2: While `cs_n` is 1, the bus and `rdwr_n` have no effect: nothing enters the store and the readback memory is not changed.
- R3: `busy` is 1 exactly when the store holds 16 bytes and the port is active. A byte held on the bus while `busy` is 1 is taken once, at the first edge where `busy` is 0.
- R4: The consumer removes at most one byte every 4 clocks, at the edge that ends the 4th cycle of a free-running phase started by reset. `cons_valid` is high for the one cycle after each removal, and `cons_data` then holds that byte.
- R5: `dout_oe` is 1 only when `cs_n` is 0, `rdwr_n` is 1 and the port is active. It is never 1 during a write.
- R6: Each edge with read selected loads `dout` with the next byte from the readback memory. The first read edge after `cs_n` was 1 returns the first byte written since reset, and the following read edges return the later bytes in write order. `cs_n` high resets the read position to the first byte.
- R7: `done` rises at the edge where the 40th byte reaches the consumer and stays 1 until reset.
- R8: With `persist` 0 and `done` 1, the port is released: `released` is 1, `dout_oe`, `busy_oe` and `busy` are 0, and writes are ignored.
- R9: With `persist` 1, the port keeps accepting writes and serving reads after `done`. `busy_oe` stays 1 and `released` stays 0.
- R10: After reset, `done`, `busy`, `cons_valid`, `released` and `dout` are 0, and the store is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock supplied by the host |
| rst_n | input | 1 | Asynchronous active-low reset |
| persist | input | 1 | Strap: 1 keeps the port alive after done |
| cs_n | input | 1 | Active-low port select |
| rdwr_n | input | 1 | Direction: 0 write, 1 read |
| din | input | 8 | Byte from the host |
| dout | output | 8 | Readback byte |
| dout_oe | output | 1 | Output enable for the data bus |
| busy | output | 1 | Flow-control flag: host must hold its byte |
| busy_oe | output | 1 | Output enable for the busy pin |
| done | output | 1 | Configuration complete |
| released | output | 1 | Pins handed over to user logic |
| cons_valid | output | 1 | Consumer took a byte in the previous cycle |
| cons_data | output | 8 | Byte taken by the consumer |

## Verification
The assertions assume a well-behaved host. `persist` stays constant between resets. The read position never runs past the bytes written since reset, so no unwritten memory location is ever read. The stimulus keeps to these limits: it changes the strap only while reset is held, reads fewer bytes than it has loaded, and holds each write byte for as long as the busy flag says so. Writes with random gaps and junk cycles with select high are mixed with back-to-back writes that fill the store.

// File: rtl/cbp_pkg.sv
package cbp_pkg;

    typedef enum logic [1:0] {
        PM_IDLE  = 2'd0,
        PM_WRITE = 2'd1,
        PM_READ  = 2'd2,
        PM_OFF   = 2'd3
    } port_mode_e;

    // Resolve what the host is asking for in this cycle.
    function automatic port_mode_e decode_mode(input logic active,
                                               input logic sel_n,
                                               input logic dir_rd);
        port_mode_e m;
        if (!active)     m = PM_OFF;
        else if (sel_n)  m = PM_IDLE;
        else if (dir_rd) m = PM_READ;
        else             m = PM_WRITE;
        return m;
    endfunction

endpackage

// File: rtl/cbp_fifo.sv
module cbp_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [DW-1:0]                wdata,
    input  logic                         pop,
    output logic [DW-1:0]                rdata,
    output logic                         full,
    output logic                         empty,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t s_d, s_q;
    logic [DW-1:0] mem_q [DEPTH];
    logic push_ok, pop_ok;

    assign full    = (s_q.cnt == FULL_CNT);
    assign empty   = (s_q.cnt == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign rdata   = mem_q[s_q.rp];
    assign count   = s_q.cnt;

    always_comb begin
        s_d = s_q;
        if (push_ok) s_d.wp = (s_q.wp == LAST_IDX) ? '0 : s_q.wp + 1'b1;
        if (pop_ok)  s_d.rp = (s_q.rp == LAST_IDX) ? '0 : s_q.rp + 1'b1;
        case ({push_ok, pop_ok})
            2'b10:   s_d.cnt = s_q.cnt + 1'b1;
            2'b01:   s_d.cnt = s_q.cnt - 1'b1;
            default: s_d.cnt = s_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem_q[s_q.wp] <= wdata;
    end
endmodule

// File: rtl/cbp_drain.sv
module cbp_drain #(
    parameter int DW     = 8,
    parameter int PERIOD = 4,
    parameter int TARGET = 40
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_empty,
    input  logic [DW-1:0] head,
    output logic          pop,
    output logic          cons_valid,
    output logic [DW-1:0] cons_data,
    output logic          done
);
    localparam int PW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam int NW = $clog2(TARGET + 1);
    localparam logic [PW-1:0] LAST_PH = PW'(PERIOD - 1);
    localparam logic [NW-1:0] GOAL    = NW'(TARGET);

    typedef struct packed {
        logic [PW-1:0] ph;
        logic [NW-1:0] used;
        logic          done;
        logic          cv;
        logic [DW-1:0] cd;
    } drain_st_t;

    drain_st_t s_d, s_q;

    assign pop        = (s_q.ph == LAST_PH) && !fifo_empty;
    assign cons_valid = s_q.cv;
    assign cons_data  = s_q.cd;
    assign done       = s_q.done;

    always_comb begin
        s_d    = s_q;
        s_d.ph = (s_q.ph == LAST_PH) ? '0 : s_q.ph + 1'b1;
        s_d.cv = pop;
        if (pop) begin
            s_d.cd = head;
            if (s_q.used != GOAL) s_d.used = s_q.used + 1'b1;
        end
        s_d.done = s_q.done || (s_d.used == GOAL);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/cbp_readback.sv
module cbp_readback #(
    parameter int DW    = 8,
    parameter int DEPTH = 256
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    input  logic          rd_en,
    input  logic          rd_clr,
    output logic [DW-1:0] rdata
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [DW-1:0] dout;
    } rb_st_t;

    rb_st_t s_d, s_q;
    logic [DW-1:0] mem_q [DEPTH];

    assign rdata = s_q.dout;

    always_comb begin
        s_d = s_q;
        if (wr_en) s_d.wp = (s_q.wp == LAST_IDX) ? '0 : s_q.wp + 1'b1;
        if (rd_en) begin
            s_d.dout = mem_q[s_q.rp];
            s_d.rp   = (s_q.rp == LAST_IDX) ? '0 : s_q.rp + 1'b1;
        end
        if (rd_clr) s_d.rp = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[s_q.wp] <= wdata;
    end
endmodule

// File: rtl/cfg_byte_port.sv
module cfg_byte_port #(
    parameter int DW           = 8,
    parameter int FIFO_DEPTH   = 16,
    parameter int DRAIN_PERIOD = 4,
    parameter int RB_DEPTH     = 256,
    parameter int CFG_BYTES    = 40
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          persist,
    input  logic          cs_n,
    input  logic          rdwr_n,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          dout_oe,
    output logic          busy,
    output logic          busy_oe,
    output logic          done,
    output logic          released,
    output logic          cons_valid,
    output logic [DW-1:0] cons_data
);
    import cbp_pkg::*;

    localparam int FCW = $clog2(FIFO_DEPTH + 1);

    port_mode_e     mode;
    logic           port_on;
    logic           fifo_full, fifo_empty, fifo_pop;
    logic           push_req, push_ok;
    logic [DW-1:0]  fifo_head;
    logic [FCW-1:0] fifo_cnt;

    assign port_on  = persist || !done;
    assign mode     = decode_mode(port_on, cs_n, rdwr_n);
    assign push_req = (mode == PM_WRITE);
    assign push_ok  = push_req && !fifo_full;

    assign busy     = port_on && fifo_full;
    assign busy_oe  = port_on;
    assign dout_oe  = (mode == PM_READ);
    assign released = !port_on;

    cbp_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push_req),
        .wdata (din),
        .pop   (fifo_pop),
        .rdata (fifo_head),
        .full  (fifo_full),
        .empty (fifo_empty),
        .count (fifo_cnt)
    );

    cbp_drain #(.DW(DW), .PERIOD(DRAIN_PERIOD), .TARGET(CFG_BYTES)) u_drain (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_empty (fifo_empty),
        .head       (fifo_head),
        .pop        (fifo_pop),
        .cons_valid (cons_valid),
        .cons_data  (cons_data),
        .done       (done)
    );

    cbp_readback #(.DW(DW), .DEPTH(RB_DEPTH)) u_rb (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (push_ok),
        .wdata  (din),
        .rd_en  (mode == PM_READ),
        .rd_clr (mode != PM_READ && mode != PM_WRITE),
        .rdata  (dout)
    );
endmodule

// File: rtl/cbp_checks.sv
module cbp_checks #(
    parameter int DEPTH = 16,
    parameter int CW    = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          persist,
    input logic          cs_n,
    input logic          rdwr_n,
    input logic          dout_oe,
    input logic          busy,
    input logic          busy_oe,
    input logic          done,
    input logic          cons_valid,
    input logic [CW-1:0] fifo_cnt
);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    assert_oe_read_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dout_oe |-> (!cs_n && rdwr_n));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= FULL_CNT);

    assert_busy_when_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (fifo_cnt == FULL_CNT));

    assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_cnt != FULL_CNT) |=> (fifo_cnt <= $past(fifo_cnt) + 1'b1));

    assert_drain_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cons_valid |=> !cons_valid);

    assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

    assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !persist) |-> (!dout_oe && !busy_oe && !busy));

    assert_keep_alive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        persist |-> busy_oe);
endmodule

bind cfg_byte_port cbp_checks #(.DEPTH(FIFO_DEPTH), .CW(FCW)) u_checks (
    .clk        (clk),
    .rst_n      (rst_n),
    .persist    (persist),
    .cs_n       (cs_n),
    .rdwr_n     (rdwr_n),
    .dout_oe    (dout_oe),
    .busy       (busy),
    .busy_oe    (busy_oe),
    .done       (done),
    .cons_valid (cons_valid),
    .fifo_cnt   (fifo_cnt)
);

// File: tb/tb_cfg_byte_port.sv
module tb_cfg_byte_port;
    localparam int DEPTH = 16;
    localparam int PER   = 4;
    localparam int CFG   = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       persist = 1'b0;
    logic       cs_n = 1'b1;
    logic       rdwr_n = 1'b0;
    logic [7:0] din = '0;
    logic [7:0] dout, cons_data;
    logic       dout_oe, busy, busy_oe, done, released, cons_valid;

    cfg_byte_port dut (
        .clk(clk), .rst_n(rst_n), .persist(persist), .cs_n(cs_n), .rdwr_n(rdwr_n),
        .din(din), .dout(dout), .dout_oe(dout_oe), .busy(busy), .busy_oe(busy_oe),
        .done(done), .released(released), .cons_valid(cons_valid), .cons_data(cons_data)
    );

    always #5 clk = ~clk;

    int total = 0;
    int bad   = 0;

    // reference state
    int         m_cnt, m_ph, m_used, m_wp, m_rp;
    bit         m_done, exp_cv, last_push;
    logic [7:0] exp_cd, m_dout;
    logic [7:0] q[$];
    logic [7:0] rb [256];
    int         busy_seen;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit port_on();
        return persist || !m_done;
    endfunction

    task automatic model_reset();
        m_cnt = 0; m_ph = 0; m_used = 0; m_wp = 0; m_rp = 0;
        m_done = 0; exp_cv = 0; exp_cd = '0; m_dout = '0; last_push = 0;
        q.delete();
    endtask

    // Advance the reference by one edge using the inputs held across it.
    task automatic model_step();
        bit on, wr, rd, push, pop;
        on   = port_on();
        wr   = on && !cs_n && !rdwr_n;
        rd   = on && !cs_n && rdwr_n;
        push = wr && (m_cnt != DEPTH);
        pop  = (m_ph == PER - 1) && (m_cnt > 0);
        exp_cv = pop;
        if (pop) exp_cd = q.pop_front();
        if (push) begin
            q.push_back(din);
            rb[m_wp] = din;
            m_wp = (m_wp + 1) % 256;
        end
        last_push = push;
        m_cnt = m_cnt + int'(push) - int'(pop);
        m_ph  = (m_ph + 1) % PER;
        if (pop && m_used < CFG) m_used++;
        if (m_used == CFG) m_done = 1;
        if (rd) begin
            m_dout = rb[m_rp];
            m_rp = (m_rp + 1) % 256;
        end
        if (cs_n || !on) m_rp = 0;
    endtask

    task automatic check_outputs();
        bit on;
        on = port_on();
        chk(busy === (on && m_cnt == DEPTH), "R3 busy", busy, on && m_cnt == DEPTH);
        chk(busy_oe === on, "R8/R9 busy_oe", busy_oe, on);
        chk(released === !on, "R8 released", released, !on);
        chk(dout_oe === (on && !cs_n && rdwr_n), "R5 dout_oe", dout_oe, on && !cs_n && rdwr_n);
        chk(cons_valid === exp_cv, "R4 cons_valid", cons_valid, exp_cv);
        if (exp_cv) chk(cons_data === exp_cd, "R1 cons_data order", cons_data, exp_cd);
        chk(dout === m_dout, "R6 dout", dout, m_dout);
        chk(done === m_done, "R7 done", done, m_done);
        if (busy) busy_seen++;
    endtask

    task automatic cycle(input logic s, input logic rw, input logic [7:0] d);
        cs_n = s; rdwr_n = rw; din = d;
        @(negedge clk);
        model_step();
        check_outputs();
    endtask

    task automatic do_reset(input logic p);
        rst_n = 1'b0; cs_n = 1'b1; rdwr_n = 1'b0;
        persist = p;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        // R10: state right after reset, before any active edge
        chk(done === 1'b0, "R10 done", done, 0);
        chk(busy === 1'b0, "R10 busy", busy, 0);
        chk(cons_valid === 1'b0, "R10 cons_valid", cons_valid, 0);
        chk(released === 1'b0, "R10 released", released, 0);
        chk(dout === 8'h00, "R10 dout", dout, 0);
    endtask

    // Host write: hold the byte until it is taken (R3); optional junk with cs_n high (R2).
    task automatic write_byte(input logic [7:0] d, input bit gaps);
        if (gaps && ($urandom % 3 == 0))
            cycle(1'b1, 1'($urandom % 2), 8'($urandom));
        do cycle(1'b0, 1'b0, d);
        while (!last_push && port_on());
    endtask

    task automatic read_n(input int n);
        for (int i = 0; i < n; i++) cycle(1'b0, 1'b1, 8'($urandom));
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // ---- persist clear ----
        do_reset(1'b0);
        busy_seen = 0;
        for (int i = 0; i < 30; i++) write_byte(8'($urandom), 1'b0);
        chk(busy_seen > 0, "R3 busy reached when store full", busy_seen, 1);
        cycle(1'b1, 1'b0, 8'h00);
        read_n(10);
        cycle(1'b1, 1'b1, 8'h00);         // R6 pointer reset
        read_n(5);
        chk(dout === rb[4], "R6 readback restart", dout, rb[4]);
        while (!m_done) write_byte(8'($urandom), 1'b1);
        chk(done === 1'b1, "R7 done after target", done, 1);
        for (int i = 0; i < 8; i++) cycle(1'b0, 1'b0, 8'($urandom));  // ignored (R8)
        read_n(3);
        chk(dout_oe === 1'b0 && busy_oe === 1'b0, "R8 outputs released", {dout_oe, busy_oe}, 0);
        for (int i = 0; i < 80; i++) cycle(1'b1, 1'b0, 8'h00);
        chk(m_cnt == 0 && released === 1'b1, "R8 no writes after release", m_cnt, 0);
        // ---- persist set ----
        do_reset(1'b1);
        for (int i = 0; i < 60; i++) write_byte(8'($urandom), 1'b1);
        chk(done === 1'b1, "R9 done with persist", done, 1);
        chk(busy_oe === 1'b1 && released === 1'b0, "R9 port kept", busy_oe, 1);
        cycle(1'b1, 1'b1, 8'h00);
        read_n(20);
        chk(dout === rb[19], "R6/R9 readback after done", dout, rb[19]);
        for (int i = 0; i < 80; i++) cycle(1'b1, 1'b0, 8'h00);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule